// File: doc/BRIEF.md
# Selectable Serial Clock Divider

This block derives the clock of a serial interface from a fast reference clock that runs on the same edge as the block itself. The division path has three stages in series. A power-of-two prescaler is set by a 3-bit select code. An optional fixed divide-by-three follows it. The last stage is either a programmable period stage or a plain 50 % toggle. No stage creates a new clock. Each stage emits a one-cycle enable pulse at its own rate, so every output stays in the reference clock domain.

The programmable stage takes a period length and a low-phase length, each written as its count minus one, so software sets the duty cycle. Select code zero parks the block for times when the serial master is idle: every counter is held cleared and both outputs stay low. The block presents two outputs. `tick_o` is a clock-enable pulse. `lvl_o` is the level of the serial clock. All five settings go into a shadow set only at an output period boundary, or at any cycle while the block is parked. Because of this, a change of setting never produces a truncated phase.

Top module: `serclk_divider`

## Requirements
- R1: With select code 0 in force, `tick_o` and `lvl_o` stay low and no pulse appears.
- R2: Select code k (1 to 7) makes the prescaler give one enable every 2^(k-1) reference cycles: code 1 undivided, code 7 divided by 64.
- R3: With `div3_i` set, the stage rate becomes one third of the prescaler rate. With it clear, the prescaler rate passes through unchanged.
- R4: With `prog_i` set, `tick_o` pulses once per output period. The period is (`tot_i`+1) stage enables long.
- R5: With `prog_i` set, `lvl_o` is low for the first (`low_i`+1) stage enables of each period and high for the rest. The tick cycle is the first low cycle.
- R6: With `prog_i` clear, `tick_o` pulses on every stage enable and `lvl_o` toggles on each one, so low and high times are equal.
- R7: Settings applied in the middle of a period take effect only after that period has completed. The period in progress keeps its old length.
- R8: With `prog_i` set and `low_i` >= `tot_i`, `lvl_o` never goes high while `tick_o` keeps its period.
- R9: During reset, and straight after it, `tick_o` and `lvl_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 3 | Prescaler select; 0 parks the block |
| div3_i | input | 1 | Adds the divide-by-three stage |
| prog_i | input | 1 | Uses the programmable period stage |
| tot_i | input | TW | Period length in stage enables, minus one |
| low_i | input | TW | Low-phase length in stage enables, minus one |
| tick_o | output | 1 | One-cycle clock-enable pulse |
| lvl_o | output | 1 | Serial clock level |

## Verification
The bench builds the block with a 6-bit period field and the divide-by-three stage present. With these values, every select code from the undivided case up to divide-by-64 can be measured as a pulse interval in a few hundred cycles, and the combined factor of 6 can be measured as well. The narrower field keeps programmed periods short, so the bench can time the low and high runs exactly, change settings halfway through a period, and try a low phase longer than the period.

// File: rtl/serclk_pkg.sv
package serclk_pkg;
   localparam int SEL_W = 3;
   // widest prescaler count: 2^(2^SEL_W - 2) cycles
   localparam int PRE_W = (1 << SEL_W) - 2;

   typedef enum logic [SEL_W-1:0] {
      SEL_PARK  = 3'd0,
      SEL_DIV1  = 3'd1,
      SEL_DIV2  = 3'd2,
      SEL_DIV4  = 3'd3,
      SEL_DIV8  = 3'd4,
      SEL_DIV16 = 3'd5,
      SEL_DIV32 = 3'd6,
      SEL_DIV64 = 3'd7
   } sel_code_e;

   // terminal count of the prescaler for a given select code
   function automatic logic [PRE_W-1:0] pre_limit(input logic [SEL_W-1:0] s);
      logic [PRE_W-1:0] r;
      r = '0;
      for (int i = 1; i < (1 << SEL_W); i++) begin
         if (s == SEL_W'(i)) r = PRE_W'((1 << (i - 1)) - 1);
      end
      return r;
   endfunction
endpackage

// File: rtl/serclk_prescaler.sv
module serclk_prescaler
   import serclk_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel_i,
   output logic             en_o
);
   logic [PRE_W-1:0] cnt_q;
   logic [PRE_W-1:0] lim;
   logic             off;

   assign lim  = pre_limit(sel_i);
   assign off  = (sel_i == SEL_PARK);
   assign en_o = !off && (cnt_q == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (off || en_o)    cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
   end

   // R2
   pre_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= pre_limit(sel_i));
endmodule

// File: rtl/serclk_div3.sv
module serclk_div3 #(
   parameter bit HAS_DIV3 = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic park_i,
   input  logic div3_i,
   input  logic en_i,
   output logic en_o
);
   if (HAS_DIV3) begin : g_div3
      logic [1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                cnt_q <= '0;
         else if (park_i || !div3_i) cnt_q <= '0;
         else if (en_i)             cnt_q <= (cnt_q == 2'd2) ? 2'd0 : cnt_q + 2'd1;
      end

      assign en_o = en_i && (!div3_i || cnt_q == 2'd2);

      // R3
      mod3_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_q != 2'd3);
   end else begin : g_pass
      assign en_o = en_i;
   end
endmodule

// File: rtl/serclk_phase.sv
module serclk_phase #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          park_i,
   input  logic          en_i,
   input  logic          prog_i,
   input  logic [TW-1:0] tot_i,
   input  logic [TW-1:0] low_i,
   output logic          wrap_o,
   output logic          tick_o,
   output logic          lvl_o
);
   logic [TW-1:0] ph_q;
   logic [TW-1:0] eff_tot;
   logic [TW-1:0] eff_low;
   logic [TW-1:0] ph_nxt;
   logic          at_end;

   // bypass behaves as a two-step period with a one-step low phase
   assign eff_tot = prog_i ? tot_i : TW'(1);
   assign eff_low = prog_i ? low_i : '0;
   assign at_end  = (ph_q == eff_tot);
   assign wrap_o  = en_i && at_end;
   assign ph_nxt  = at_end ? '0 : ph_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= '0;
         lvl_o  <= 1'b0;
         tick_o <= 1'b0;
      end else if (park_i) begin
         ph_q   <= '0;
         lvl_o  <= 1'b0;
         tick_o <= 1'b0;
      end else begin
         tick_o <= en_i && (!prog_i || at_end);
         if (en_i) begin
            ph_q  <= ph_nxt;
            lvl_o <= (ph_nxt > eff_low);
         end
      end
   end

   // R4
   phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ph_q <= eff_tot);

   // R5
   low_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && ph_q == '0) |-> !lvl_o);
endmodule

// File: rtl/serclk_divider.sv
module serclk_divider
   import serclk_pkg::*;
#(
   parameter int TW       = 8,
   parameter bit HAS_DIV3 = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    sel_i,
   input  logic          div3_i,
   input  logic          prog_i,
   input  logic [TW-1:0] tot_i,
   input  logic [TW-1:0] low_i,
   output logic          tick_o,
   output logic          lvl_o
);
   if (TW < 2) begin : g_bad_tw
      $error("serclk_divider: TW must be at least 2");
   end
   if (SEL_W != 3) begin : g_bad_sel
      $error("serclk_divider: select width must be 3");
   end

   sel_code_e     act_sel;
   logic          act_div3;
   logic          act_prog;
   logic [TW-1:0] act_tot;
   logic [TW-1:0] act_low;
   logic          park;
   logic          pre_en;
   logic          stage_en;
   logic          wrap;
   logic          load;

   assign park = (act_sel == SEL_PARK);
   assign load = park || wrap;

   // shadow settings, refreshed only at a period boundary or while parked
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_sel  <= SEL_PARK;
         act_div3 <= 1'b0;
         act_prog <= 1'b0;
         act_tot  <= '0;
         act_low  <= '0;
      end else if (load) begin
         act_sel  <= sel_code_e'(sel_i);
         act_div3 <= div3_i;
         act_prog <= prog_i;
         act_tot  <= tot_i;
         act_low  <= low_i;
      end
   end

   serclk_prescaler u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .sel_i (act_sel),
      .en_o  (pre_en)
   );

   serclk_div3 #(.HAS_DIV3(HAS_DIV3)) u_div3 (
      .clk    (clk),
      .rst_n  (rst_n),
      .park_i (park),
      .div3_i (act_div3),
      .en_i   (pre_en),
      .en_o   (stage_en)
   );

   serclk_phase #(.TW(TW)) u_phase (
      .clk    (clk),
      .rst_n  (rst_n),
      .park_i (park),
      .en_i   (stage_en),
      .prog_i (act_prog),
      .tot_i  (act_tot),
      .low_i  (act_low),
      .wrap_o (wrap),
      .tick_o (tick_o),
      .lvl_o  (lvl_o)
   );

   // R7
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!park && !wrap) |=> ($stable(act_sel) && $stable(act_div3) &&
                            $stable(act_prog) && $stable(act_tot) && $stable(act_low)));

   // R1
   parked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (park && $past(park)) |-> (!tick_o && !lvl_o));
endmodule

// File: tb/tb_serclk_divider.sv
module tb_serclk_divider;
   localparam int TW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    sel = 3'd0;
   logic          div3 = 1'b0;
   logic          prog = 1'b0;
   logic [TW-1:0] tot = '0;
   logic [TW-1:0] low = '0;
   logic          tick;
   logic          lvl;

   int n_run = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   serclk_divider #(.TW(TW), .HAS_DIV3(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .sel_i(sel), .div3_i(div3), .prog_i(prog),
      .tot_i(tot), .low_i(low), .tick_o(tick), .lvl_o(lvl)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         n_run++; n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic apply(input int s, input bit d3, input bit pg, input int t, input int l);
      sel  = 3'(s);
      div3 = d3;
      prog = pg;
      tot  = TW'(t);
      low  = TW'(l);
   endtask

   task automatic wait_tick();
      int n = 0;
      do begin @(negedge clk); n++; end while (!tick && n < 3000);
   endtask

   task automatic cycles_to_tick(output int n);
      n = 0;
      do begin @(negedge clk); n++; end while (!tick && n < 3000);
   endtask

   task automatic settle();
      for (int i = 0; i < 4; i++) wait_tick();
   endtask

   task automatic level_run(output int n);
      logic prev;
      int g = 0;
      prev = lvl;
      do begin @(negedge clk); g++; end while (lvl == prev && g < 3000);
      prev = lvl;
      n = 0;
      while (lvl == prev && n < 3000) begin n++; @(negedge clk); end
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R9 tick in reset", int'(tick), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 level after reset", int'(lvl), 0);
   endtask

   task automatic t_bypass(input int s);
      int n, exp;
      exp = 1 << (s - 1);
      apply(s, 1'b0, 1'b0, 0, 0);
      settle();
      wait_tick();
      cycles_to_tick(n);
      chk($sformatf("R2 tick interval sel %0d", s), n, exp);
      level_run(n);
      chk($sformatf("R6 level run sel %0d", s), n, exp);
   endtask

   task automatic t_div3();
      int n;
      apply(2, 1'b1, 1'b0, 0, 0);
      settle();
      wait_tick();
      cycles_to_tick(n);
      chk("R3 tick interval /2 /3", n, 6);
      level_run(n);
      chk("R3 level run /2 /3", n, 6);
   endtask

   task automatic t_prog(input int s, input bit d3, input int t, input int l);
      int sd, nl, nh;
      sd = (1 << (s - 1)) * (d3 ? 3 : 1);
      apply(s, d3, 1'b1, t, l);
      settle();
      wait_tick();
      nl = 0;
      while (!lvl && nl < 3000) begin nl++; @(negedge clk); end
      nh = 0;
      while (lvl && nh < 3000) begin nh++; @(negedge clk); end
      chk("R5 low run", nl, (l + 1) * sd);
      chk("R5 high run", nh, (t - l) * sd);
      chk("R4 tick at period end", int'(tick), 1);
      chk("R4 period", nl + nh, (t + 1) * sd);
   endtask

   task automatic t_lowbig();
      int n, hi;
      apply(1, 1'b0, 1'b1, 2, 5);
      settle();
      wait_tick();
      cycles_to_tick(n);
      chk("R8 period kept", n, 3);
      hi = 0;
      for (int i = 0; i < 60; i++) begin @(negedge clk); if (lvl) hi++; end
      chk("R8 level never high", hi, 0);
   endtask

   task automatic t_boundary();
      int n;
      apply(1, 1'b0, 1'b1, 9, 4);
      settle();
      wait_tick();
      n = 0;
      do begin
         @(negedge clk); n++;
         if (n == 3) apply(1, 1'b0, 1'b1, 3, 1);
      end while (!tick && n < 3000);
      chk("R7 running period keeps old length", n, 10);
      cycles_to_tick(n);
      chk("R7 next period uses new length", n, 4);
   endtask

   task automatic t_park();
      int act;
      apply(0, 1'b0, 1'b0, 0, 0);
      repeat (200) @(negedge clk);
      act = 0;
      for (int i = 0; i < 80; i++) begin @(negedge clk); if (tick || lvl) act++; end
      chk("R1 parked outputs quiet", act, 0);
   endtask

   initial begin
      t_reset();
      t_bypass(1);
      t_bypass(3);
      t_bypass(7);
      t_div3();
      t_prog(1, 1'b0, 4, 1);
      t_prog(2, 1'b1, 3, 0);
      t_lowbig();
      t_boundary();
      t_park();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule